// File: doc/BRIEF.md
# Block and Flash Write Color Datapath

This block is the write datapath of a memory with 16-bit words. It holds a 16-bit color word and applies it to memory in two wide forms. A block write stores the color into up to eight neighbouring columns of one column group in a single command. A flash write stores the color across an entire row. An ordinary single-column write with data from the bus uses the same datapath. For every bit written, the block works out whether it takes the new value or keeps the old one. That decision combines three things: a per-column mask taken from the data bus, two byte-lane enables, and a write-per-bit mask.

Each command lasts one clock cycle and its results appear on registered outputs one cycle later. For the column group addressed, the array supplies the current contents of its eight columns on `old_data`. The block returns a merged word for each column together with a write enable per column. Flash writes are reported as a bit-enable vector and a color word for the array's row-fill logic. The write-per-bit mask comes from one of two sources, chosen by a two-state mode machine. In the direct mode (`MODE_DIRECT`) the mask is taken fresh from `bmask_in` on every command. In the held mode (`MODE_HELD`) a stored mask stays in force until it is cleared. The transition `LOAD_MASK` moves the machine from either state to `MODE_HELD`. The transition `CLEAR_MASK` moves it from either state to `MODE_DIRECT`. Every other command leaves the state unchanged. Reset enters `MODE_DIRECT`.

Top module: `blkwr_datapath`

## Requirements
- R1: After reset all outputs are 0, the color register reads back as 0, the mode is `MODE_DIRECT` and the stored mask is all ones.
- R2: `cmd_op`=4 (load color) stores `wdata` into the color register. `cmd_op`=5 (read color) gives `rd_valid`=1 and `rd_data`=color one cycle later. A load is visible to the command that follows it.
- R3: `cmd_op`=2 (block write) treats `col_addr[2:0]` as don't-care. `grp_addr` is `col_addr[8:3]` and column i of the group is `old_data[16*i+15:16*i]`. Each enabled bit takes the color; every other bit keeps its old value.
- R4: In a block write, `wdata[i]` enables column i in the lower byte (bits 7:0), and `wdata[8+i]` enables column i in the upper byte (bits 15:8), for i = 0 to 7. A mask bit of 0 inhibits that byte of that column.
- R5: `be_lo` gates bits 7:0 and `be_hi` gates bits 15:8 for every write kind. `col_we[i]` is 1 when at least one bit of column i is enabled.
- R6: With `wpb_en`=1 in `MODE_DIRECT`, `bmask_in` is the bit mask for that command only. A mask bit of 0 keeps the old bit.
- R7: `cmd_op`=6 (load mask) stores `wdata` as the held mask and enters `MODE_HELD`. While in `MODE_HELD`, `wpb_en`=1 uses the held mask and `bmask_in` is ignored. `cmd_op`=7 (clear mask) returns to `MODE_DIRECT`.
- R8: `cmd_op`=3 (flash write) gives `flash_bits` equal to the effective bit mask, `flash_color` equal to the color, and `flash_we` equal to the OR of `flash_bits`, with `col_we`=0. For any other command these three outputs are 0.
- R9: `cmd_op`=1 (write) merges `wdata` into column `col_addr[2:0]` under the effective bit mask. No other column is enabled.
- R10: With `wpb_en`=0, all 16 bits are enabled (before byte gating), in either mode.
- R11: Results appear one cycle after the command. `cmd_op`=0 (no operation) produces `col_we`=0, `grp_addr`=0, `flash_we`=0 and `rd_valid`=0. For any command that writes no column, `col_data` equals `old_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 3 | Command code (0 nop, 1 write, 2 block, 3 flash, 4 load color, 5 read color, 6 load mask, 7 clear mask) |
| col_addr | input | 9 | Column address |
| wdata | input | 16 | Data bus: write data, column masks, color or mask value |
| wpb_en | input | 1 | Write-per-bit enable |
| bmask_in | input | 16 | Per-command bit mask used in direct mode |
| be_lo | input | 1 | Lower byte enable |
| be_hi | input | 1 | Upper byte enable |
| old_data | input | 128 | Current contents of the eight columns of the group |
| col_we | output | 8 | Per-column write enable |
| grp_addr | output | 6 | Column group address of the write |
| col_data | output | 128 | Merged word per column |
| flash_we | output | 1 | Row flash write strobe |
| flash_bits | output | 16 | Bit enables of the flash write |
| flash_color | output | 16 | Color used by the flash write |
| rd_valid | output | 1 | Color readback valid |
| rd_data | output | 16 | Color readback value |

## Verification
The bench targets the corner cases where a wrong design visibly misbehaves. It drives a block write with nonzero low address bits; a design that used those bits would report the wrong group. It uses column masks that differ between the two byte lanes; a design that swapped or shared the lanes would write bytes that should be inhibited. It sends a differing `bmask_in` while the held mask is in force; a design that forgot the mode would follow the per-command mask. Finally, it issues a load color immediately followed by a block write; a design that took the color one cycle late would write the stale color.

// File: rtl/blkwr_pkg.sv
package blkwr_pkg;
    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_WRITE  = 3'd1,
        OP_BLOCK  = 3'd2,
        OP_FLASH  = 3'd3,
        OP_LDCOL  = 3'd4,
        OP_RDCOL  = 3'd5,
        OP_LDMASK = 3'd6,
        OP_CLRMSK = 3'd7
    } op_e;

    typedef enum logic {
        MODE_DIRECT = 1'b0,
        MODE_HELD   = 1'b1
    } mode_e;
endpackage

// File: rtl/blkwr_mask_unit.sv
module blkwr_mask_unit
    import blkwr_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  op_e           op,
    input  logic [DW-1:0] wdata,
    input  logic          wpb_en,
    input  logic [DW-1:0] bmask_in,
    input  logic          be_lo,
    input  logic          be_hi,
    output logic [DW-1:0] bit_en,
    output logic          mode_held
);
    localparam int HALF = DW / 2;

    mode_e         state_q, state_d;
    logic [DW-1:0] mask_q;
    logic [DW-1:0] src_mask;
    logic [DW-1:0] lane_mask;

    // state register and held mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MODE_DIRECT;
            mask_q  <= '1;
        end else begin
            state_q <= state_d;
            if (op == OP_LDMASK)
                mask_q <= wdata;
        end
    end

    // transitions: LOAD_MASK -> MODE_HELD, CLEAR_MASK -> MODE_DIRECT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_DIRECT: if (op == OP_LDMASK) state_d = MODE_HELD;
            MODE_HELD:   if (op == OP_CLRMSK) state_d = MODE_DIRECT;
            default:     state_d = MODE_DIRECT;
        endcase
    end

    // mask selection
    always_comb begin
        if (!wpb_en)
            src_mask = '1;
        else if (state_q == MODE_HELD)
            src_mask = mask_q;
        else
            src_mask = bmask_in;
        lane_mask = {{HALF{be_hi}}, {HALF{be_lo}}};
        bit_en    = src_mask & lane_mask;
    end

    assign mode_held = (state_q == MODE_HELD);
endmodule

// File: rtl/blkwr_color_reg.sv
module blkwr_color_reg
    import blkwr_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  op_e           op,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] color,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            color    <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            if (op == OP_LDCOL)
                color <= wdata;
            rd_valid <= (op == OP_RDCOL);
            rd_data  <= (op == OP_RDCOL) ? color : '0;
        end
    end
endmodule

// File: rtl/blkwr_col_merge.sv
module blkwr_col_merge #(
    parameter int DW  = 16,
    parameter int BLK = 8,
    parameter int SW  = 3
) (
    input  logic              is_block,
    input  logic              is_write,
    input  logic [SW-1:0]     col_sel,
    input  logic [DW-1:0]     bit_en,
    input  logic [DW-1:0]     color,
    input  logic [DW-1:0]     wdata,
    input  logic [BLK*DW-1:0] old_data,
    output logic [BLK-1:0]    we,
    output logic [BLK*DW-1:0] merged
);
    localparam int LANE = 8;

    for (genvar gi = 0; gi < BLK; gi++) begin : g_col
        logic [DW-1:0] en;
        logic [DW-1:0] src;
        logic [DW-1:0] prev;

        assign prev = old_data[gi*DW +: DW];

        always_comb begin
            for (int b = 0; b < DW; b++) begin
                if (is_block)
                    en[b] = bit_en[b] & wdata[(b / LANE) * LANE + gi];
                else if (is_write && (col_sel == SW'(gi)))
                    en[b] = bit_en[b];
                else
                    en[b] = 1'b0;
            end
            src = is_block ? color : wdata;
        end

        assign merged[gi*DW +: DW] = (src & en) | (prev & ~en);
        assign we[gi]              = |en;
    end
endmodule

// File: rtl/blkwr_datapath.sv
module blkwr_datapath
    import blkwr_pkg::*;
#(
    parameter int DW    = 16,
    parameter int COL_W = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          cmd_op,
    input  logic [COL_W-1:0]    col_addr,
    input  logic [DW-1:0]       wdata,
    input  logic                wpb_en,
    input  logic [DW-1:0]       bmask_in,
    input  logic                be_lo,
    input  logic                be_hi,
    input  logic [8*DW-1:0]     old_data,
    output logic [7:0]          col_we,
    output logic [COL_W-4:0]    grp_addr,
    output logic [8*DW-1:0]     col_data,
    output logic                flash_we,
    output logic [DW-1:0]       flash_bits,
    output logic [DW-1:0]       flash_color,
    output logic                rd_valid,
    output logic [DW-1:0]       rd_data
);
    localparam int BLK = 8;
    localparam int SW  = $clog2(BLK);
    localparam int GW  = COL_W - SW;

    op_e              op;
    logic [DW-1:0]    bit_en;
    logic             mode_held;
    logic [DW-1:0]    color;
    logic [BLK-1:0]   m_we;
    logic [BLK*DW-1:0] m_data;
    logic             is_block, is_write;

    logic [BLK-1:0]   we_d;
    logic [GW-1:0]    grp_d;
    logic             fwe_d;
    logic [DW-1:0]    fbits_d, fcol_d;

    assign op = op_e'(cmd_op);

    blkwr_mask_unit #(.DW(DW)) u_mask (
        .clk(clk), .rst_n(rst_n), .op(op), .wdata(wdata),
        .wpb_en(wpb_en), .bmask_in(bmask_in), .be_lo(be_lo), .be_hi(be_hi),
        .bit_en(bit_en), .mode_held(mode_held)
    );

    blkwr_color_reg #(.DW(DW)) u_color (
        .clk(clk), .rst_n(rst_n), .op(op), .wdata(wdata),
        .color(color), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    blkwr_col_merge #(.DW(DW), .BLK(BLK), .SW(SW)) u_merge (
        .is_block(is_block), .is_write(is_write), .col_sel(col_addr[SW-1:0]),
        .bit_en(bit_en), .color(color), .wdata(wdata), .old_data(old_data),
        .we(m_we), .merged(m_data)
    );

    // output decode
    always_comb begin
        is_block = 1'b0;
        is_write = 1'b0;
        we_d     = '0;
        grp_d    = '0;
        fwe_d    = 1'b0;
        fbits_d  = '0;
        fcol_d   = '0;
        unique case (op)
            OP_WRITE: begin
                is_write = 1'b1;
                we_d     = m_we;
                grp_d    = col_addr[COL_W-1:SW];
            end
            OP_BLOCK: begin
                is_block = 1'b1;
                we_d     = m_we;
                grp_d    = col_addr[COL_W-1:SW];
            end
            OP_FLASH: begin
                fbits_d = bit_en;
                fcol_d  = color;
                fwe_d   = |bit_en;
            end
            OP_NOP, OP_LDCOL, OP_RDCOL, OP_LDMASK, OP_CLRMSK: ;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_we      <= '0;
            grp_addr    <= '0;
            col_data    <= '0;
            flash_we    <= 1'b0;
            flash_bits  <= '0;
            flash_color <= '0;
        end else begin
            col_we      <= we_d;
            grp_addr    <= grp_d;
            col_data    <= m_data;
            flash_we    <= fwe_d;
            flash_bits  <= fbits_d;
            flash_color <= fcol_d;
        end
    end
endmodule

// File: rtl/blkwr_datapath_chk.sv
module blkwr_datapath_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    cmd_op,
    input logic [DW-1:0] wdata,
    input logic          be_lo,
    input logic          be_hi,
    input logic [7:0]    col_we,
    input logic          flash_we,
    input logic          rd_valid,
    input logic          mode_held
);
    // R8
    flash_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flash_we |-> (col_we == 8'h00));

    // R2
    read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 3'd5) |=> rd_valid);

    // R7
    mask_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 3'd6) |=> mode_held);

    // R4
    blk_colmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 3'd2) |=>
            ((col_we & ~($past(wdata[7:0]) | $past(wdata[DW-1:DW-8]))) == 8'h00));

    // R5
    lanes_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_op == 3'd2) && !be_lo && !be_hi) |=> (col_we == 8'h00));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 3'd0) |=> (col_we == 8'h00 && !flash_we && !rd_valid));
endmodule

bind blkwr_datapath blkwr_datapath_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .wdata(wdata),
    .be_lo(be_lo), .be_hi(be_hi), .col_we(col_we), .flash_we(flash_we),
    .rd_valid(rd_valid), .mode_held(mode_held)
);

// File: tb/blkwr_datapath_test.sv
module blkwr_datapath_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   cmd_op = 3'd0;
    logic [8:0]   col_addr = '0;
    logic [15:0]  wdata = '0;
    logic         wpb_en = 1'b0;
    logic [15:0]  bmask_in = '0;
    logic         be_lo = 1'b0;
    logic         be_hi = 1'b0;
    logic [127:0] old_data = '0;
    logic [7:0]   col_we;
    logic [5:0]   grp_addr;
    logic [127:0] col_data;
    logic         flash_we;
    logic [15:0]  flash_bits, flash_color;
    logic         rd_valid;
    logic [15:0]  rd_data;

    always #10 clk = ~clk;

    blkwr_datapath uut (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .col_addr(col_addr),
        .wdata(wdata), .wpb_en(wpb_en), .bmask_in(bmask_in), .be_lo(be_lo),
        .be_hi(be_hi), .old_data(old_data), .col_we(col_we), .grp_addr(grp_addr),
        .col_data(col_data), .flash_we(flash_we), .flash_bits(flash_bits),
        .flash_color(flash_color), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    typedef struct packed {
        logic [7:0]   we;
        logic [5:0]   grp;
        logic [127:0] data;
        logic         fwe;
        logic [15:0]  fbits;
        logic [15:0]  fcol;
        logic         rv;
        logic [15:0]  rd;
    } exp_t;

    exp_t  eq[$];
    string tq[$];
    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;

    logic [15:0] m_color = 16'h0000;
    logic [15:0] m_mask  = 16'hFFFF;
    bit          m_held  = 1'b0;

    function automatic logic [127:0] mk_old(input logic [15:0] seed);
        logic [127:0] r;
        for (int i = 0; i < 8; i++)
            r[i*16 +: 16] = seed ^ (16'h1111 * 16'(i)) ^ 16'(i << 12);
        return r;
    endfunction

    // driver: drive one command and push its expected result
    task automatic issue(input logic [2:0] op, input logic [8:0] col,
                         input logic [15:0] wd, input logic wpb,
                         input logic [15:0] bm, input logic bl, input logic bh,
                         input logic [127:0] old, input string tag);
        exp_t e;
        logic [15:0] src, ben, en;
        cmd_op = op; col_addr = col; wdata = wd; wpb_en = wpb;
        bmask_in = bm; be_lo = bl; be_hi = bh; old_data = old;
        src = !wpb ? 16'hFFFF : (m_held ? m_mask : bm);
        ben = src & {{8{bh}}, {8{bl}}};
        e = '0;
        e.data = old;
        case (op)
            3'd1: begin
                en = ben;
                e.data[col[2:0]*16 +: 16] = (wd & en) | (old[col[2:0]*16 +: 16] & ~en);
                e.we[col[2:0]] = |en;
                e.grp = col[8:3];
            end
            3'd2: begin
                for (int i = 0; i < 8; i++) begin
                    en = ben & {{8{wd[8+i]}}, {8{wd[i]}}};
                    e.data[i*16 +: 16] = (m_color & en) | (old[i*16 +: 16] & ~en);
                    e.we[i] = |en;
                end
                e.grp = col[8:3];
            end
            3'd3: begin
                e.fbits = ben; e.fcol = m_color; e.fwe = |ben;
            end
            3'd5: begin
                e.rv = 1'b1; e.rd = m_color;
            end
            default: ;
        endcase
        if (op == 3'd4) m_color = wd;
        if (op == 3'd6) begin m_mask = wd; m_held = 1'b1; end
        if (op == 3'd7) m_held = 1'b0;
        @(posedge clk);
        eq.push_back(e);
        tq.push_back(tag);
        @(negedge clk);
    endtask

    // monitor: compare design output against queued expectation
    initial begin
        forever begin
            @(negedge clk);
            if (eq.size() > 0) begin
                exp_t e;
                string t;
                exp_t a;
                e = eq.pop_front();
                t = tq.pop_front();
                a = '{we: col_we, grp: grp_addr, data: col_data, fwe: flash_we,
                      fbits: flash_bits, fcol: flash_color, rv: rd_valid, rd: rd_data};
                checks++;
                if (a !== e) begin
                    fails++;
                    $display("FAIL %s: actual we=%h grp=%h data=%h fwe=%b fb=%h fc=%h rv=%b rd=%h expected we=%h grp=%h data=%h fwe=%b fb=%h fc=%h rv=%b rd=%h",
                             t, a.we, a.grp, a.data, a.fwe, a.fbits, a.fcol, a.rv, a.rd,
                             e.we, e.grp, e.data, e.fwe, e.fbits, e.fcol, e.rv, e.rd);
                end
            end
        end
    end

    initial begin
        repeat (1000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state at the ports
        checks++;
        if (col_we !== 8'h00 || grp_addr !== 6'h00 || col_data !== '0 || flash_we !== 1'b0 ||
            flash_bits !== 16'h0 || flash_color !== 16'h0 || rd_valid !== 1'b0 || rd_data !== 16'h0) begin
            fails++;
            $display("FAIL R1: actual we=%h rv=%b fwe=%b expected all zero", col_we, rd_valid, flash_we);
        end
        rst_n = 1'b1;
        issue(3'd5, 9'h000, 16'h0000, 0, 16'h0, 1, 1, mk_old(16'h0101), "R1 color reset");
        issue(3'd4, 9'h000, 16'hA5C3, 0, 16'h0, 1, 1, mk_old(16'h0202), "R2 load color");
        issue(3'd5, 9'h000, 16'h0000, 0, 16'h0, 1, 1, mk_old(16'h0303), "R2 read color");
        issue(3'd2, 9'h0AD, 16'h0FA5, 0, 16'h0, 1, 1, mk_old(16'h4321), "R3 R4 block");
        issue(3'd2, 9'h1F8, 16'h3CC3, 0, 16'h0, 1, 0, mk_old(16'h5A5A), "R5 lower lane");
        issue(3'd2, 9'h007, 16'h3CC3, 0, 16'h0, 0, 1, mk_old(16'h5A5A), "R5 upper lane");
        issue(3'd2, 9'h0AD, 16'hFFFF, 0, 16'h0, 0, 0, mk_old(16'h7777), "R5 no lanes");
        issue(3'd2, 9'h042, 16'hFFFF, 1, 16'h0FF0, 1, 1, mk_old(16'h0000), "R6 direct mask block");
        issue(3'd1, 9'h013, 16'h1234, 0, 16'h0, 1, 1, mk_old(16'hFEDC), "R9 write");
        issue(3'd1, 9'h1FE, 16'h1234, 1, 16'h00FF, 1, 1, mk_old(16'hFEDC), "R6 R9 masked write");
        issue(3'd6, 9'h000, 16'hF00F, 0, 16'h0, 1, 1, mk_old(16'h1111), "R7 load mask");
        issue(3'd2, 9'h0C1, 16'hFFFF, 1, 16'h0000, 1, 1, mk_old(16'h0000), "R7 held mask block");
        issue(3'd1, 9'h0C5, 16'hBEEF, 1, 16'hFFFF, 1, 1, mk_old(16'h2222), "R7 held mask write");
        issue(3'd2, 9'h0C1, 16'h8181, 0, 16'h0000, 1, 1, mk_old(16'h3333), "R10 held no wpb");
        issue(3'd7, 9'h000, 16'h0000, 0, 16'h0, 1, 1, mk_old(16'h4444), "R7 clear mask");
        issue(3'd2, 9'h0C1, 16'hFFFF, 1, 16'h3C3C, 1, 1, mk_old(16'h0000), "R7 direct again");
        issue(3'd3, 9'h000, 16'h0000, 1, 16'hAAAA, 1, 1, mk_old(16'h5555), "R8 flash masked");
        issue(3'd3, 9'h000, 16'h0000, 0, 16'h0, 1, 0, mk_old(16'h6666), "R8 flash lower");
        issue(3'd3, 9'h000, 16'h0000, 1, 16'h0000, 1, 1, mk_old(16'h6666), "R8 flash empty");
        issue(3'd0, 9'h0AD, 16'hFFFF, 0, 16'h0, 1, 1, mk_old(16'h9999), "R11 nop");
        issue(3'd4, 9'h000, 16'h3E7C, 0, 16'h0, 1, 1, mk_old(16'h0000), "R2 R11 reload");
        issue(3'd2, 9'h100, 16'h55AA, 0, 16'h0, 1, 1, mk_old(16'hC0DE), "R2 new color used");
        issue(3'd0, 9'h000, 16'h0000, 0, 16'h0, 0, 0, mk_old(16'h0000), "R11 drain");
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule